// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the first decoding level of a processor that completes each instruction in one clock cycle. It looks only at the 6-bit opcode field, taken from instruction bits 31 to 26. From it the block produces the control signals that steer the datapath for the current instruction. These signals choose the destination register field and the second ALU operand. They pick the write-back source and enable the register file and data memory. They also flag control-flow instructions and pass a 2-bit operation class to a separate ALU control decoder. That second decoder selects the exact ALU operation, which is not done here.

The block has no clock and no state. Its outputs settle from the opcode within the same cycle. Five instruction classes are recognised: register-register arithmetic and logic, load word, store word, branch-if-equal and jump. Any other opcode decodes to a harmless no-operation that writes nothing and does not redirect the program counter.

Top module: `main_ctrl_dec`

## Requirements
- R1: Opcode 6'h00 (register-register) gives rf_we_o=1, dst_sel_rd_o=1, alu_b_imm_o=0 and alu_class_o=2'b10. Every other output is 0.
- R2: Opcode 6'h23 (load word) gives rf_we_o=1, dmem_re_o=1, wb_from_mem_o=1, alu_b_imm_o=1, dst_sel_rd_o=0 and alu_class_o=2'b00. Every other output is 0.
- R3: Opcode 6'h2B (store word) gives dmem_we_o=1, alu_b_imm_o=1 and alu_class_o=2'b00. Every other output is 0, including rf_we_o.
- R4: Opcode 6'h04 (branch-if-equal) gives is_branch_o=1, alu_b_imm_o=0 and alu_class_o=2'b01. Every other output is 0.
- R5: Opcode 6'h02 (jump) gives is_jump_o=1, alu_b_imm_o=1 and alu_class_o=2'b00. Every other output is 0.
- R6: Every opcode other than the five above drives all outputs to 0.
- R7: For every opcode, at most one of rf_we_o, dmem_we_o, is_branch_o and is_jump_o is 1. Also, dmem_re_o=1 only when wb_from_mem_o=1 and rf_we_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Instruction opcode field (bits 31..26) |
| dst_sel_rd_o | output | 1 | 1: write to the rd field, 0: write to the rt field |
| alu_b_imm_o | output | 1 | 1: ALU second operand is the sign-extended immediate, 0: second register |
| wb_from_mem_o | output | 1 | Register write-back data taken from data memory |
| rf_we_o | output | 1 | Register file write enable |
| dmem_re_o | output | 1 | Data memory read enable |
| dmem_we_o | output | 1 | Data memory write enable |
| is_branch_o | output | 1 | Instruction is branch-if-equal |
| is_jump_o | output | 1 | Instruction is a jump |
| alu_class_o | output | 2 | Operation class for the ALU control decoder |

## Verification
The situation that is hardest to reach is an unused opcode that sits one bit away from a valid one, such as 6'h22, 6'h2A or 6'h06. A decoder that ignores a bit would treat such an opcode as a real instruction and enable a write. A few hand-picked opcodes rarely land on these neighbours. The bench therefore walks the whole 64-value opcode space and checks every unused code for a fully quiet output. It then checks the exclusion and load-path rules on every value as well.

// File: rtl/main_ctrl_dec.sv
module main_ctrl_dec #(
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OP_RRR   = 6'h00,
  parameter logic [OPW-1:0] OP_LOAD  = 6'h23,
  parameter logic [OPW-1:0] OP_STORE = 6'h2B,
  parameter logic [OPW-1:0] OP_BEQ   = 6'h04,
  parameter logic [OPW-1:0] OP_JUMP  = 6'h02
) (
  input  logic [OPW-1:0] opcode_i,
  output logic           dst_sel_rd_o,
  output logic           alu_b_imm_o,
  output logic           wb_from_mem_o,
  output logic           rf_we_o,
  output logic           dmem_re_o,
  output logic           dmem_we_o,
  output logic           is_branch_o,
  output logic           is_jump_o,
  output logic [1:0]     alu_class_o
);

  localparam int CW = 10;
  // ctl order: rf_we, dst_rd, b_imm, wb_mem, dm_re, dm_we, branch, jump, class[1:0]
  logic [CW-1:0] ctl;

  always_comb begin
    unique case (opcode_i)
      OP_RRR:   ctl = 10'b1100000010;
      OP_LOAD:  ctl = 10'b1011100000;
      OP_STORE: ctl = 10'b0010010000;
      OP_BEQ:   ctl = 10'b0000001001;
      OP_JUMP:  ctl = 10'b0010000100;
      default:  ctl = '0;
    endcase
  end

  assign {rf_we_o, dst_sel_rd_o, alu_b_imm_o, wb_from_mem_o, dmem_re_o,
          dmem_we_o, is_branch_o, is_jump_o, alu_class_o} = ctl;

  logic known_op;
  assign known_op = (opcode_i == OP_RRR) || (opcode_i == OP_LOAD) ||
                    (opcode_i == OP_STORE) || (opcode_i == OP_BEQ) ||
                    (opcode_i == OP_JUMP);

  always_comb begin
    p_single_action_r7: assert ($onehot0({rf_we_o, dmem_we_o, is_branch_o, is_jump_o}))
      else $error("more than one action enabled");
    p_load_path_r7: assert (!dmem_re_o || (wb_from_mem_o && rf_we_o && alu_b_imm_o))
      else $error("memory read without write-back path");
    p_rd_dest_r1: assert (!dst_sel_rd_o || (alu_class_o == 2'b10 && !alu_b_imm_o && rf_we_o))
      else $error("rd destination outside register-register class");
    p_branch_sub_r4: assert (!is_branch_o || (alu_class_o == 2'b01 && !alu_b_imm_o))
      else $error("branch without compare class");
    p_unknown_quiet_r6: assert (known_op || {rf_we_o, dmem_we_o, dmem_re_o, is_branch_o, is_jump_o} == 5'b0)
      else $error("unrecognised opcode enabled an action");
  end

endmodule

// File: tb/main_ctrl_dec_tb.sv
`timescale 1ns/1ps
module main_ctrl_dec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [5:0] opcode;
  logic dst_rd, b_imm, wb_mem, rf_we, dm_re, dm_we, br, jmp;
  logic [1:0] acls;

  main_ctrl_dec dut_i (
    .opcode_i(opcode), .dst_sel_rd_o(dst_rd), .alu_b_imm_o(b_imm),
    .wb_from_mem_o(wb_mem), .rf_we_o(rf_we), .dmem_re_o(dm_re),
    .dmem_we_o(dm_we), .is_branch_o(br), .is_jump_o(jmp), .alu_class_o(acls)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [9:0] observed();
    return {rf_we, dst_rd, b_imm, wb_mem, dm_re, dm_we, br, jmp, acls};
  endfunction

  task automatic drive_check(input logic [5:0] op, input logic [9:0] exp, input string req);
    @(negedge clk);
    opcode = op;
    #1;
    checks++;
    if (observed() !== exp) begin
      errors++;
      $display("FAIL %s op=%h actual=%b expected=%b", req, op, observed(), exp);
    end
  endtask

  task automatic t_idle;
    drive_check(6'h3F, 10'b0, "R6 idle-after-reset");
  endtask

  task automatic t_rrr_r1;
    drive_check(6'h00, 10'b1100000010, "R1");
  endtask

  task automatic t_load_r2;
    drive_check(6'h23, 10'b1011100000, "R2");
  endtask

  task automatic t_store_r3;
    drive_check(6'h2B, 10'b0010010000, "R3");
  endtask

  task automatic t_beq_r4;
    drive_check(6'h04, 10'b0000001001, "R4");
  endtask

  task automatic t_jump_r5;
    drive_check(6'h02, 10'b0010000100, "R5");
  endtask

  task automatic t_sweep_r6_r7;
    for (int i = 0; i < 64; i++) begin
      logic [5:0] op;
      logic [9:0] exp;
      op = 6'(i);
      case (op)
        6'h00: exp = 10'b1100000010;
        6'h23: exp = 10'b1011100000;
        6'h2B: exp = 10'b0010010000;
        6'h04: exp = 10'b0000001001;
        6'h02: exp = 10'b0010000100;
        default: exp = 10'b0;
      endcase
      drive_check(op, exp, "R6 sweep");
      checks++;
      if ($countones({rf_we, dm_we, br, jmp}) > 1 || (dm_re && !(wb_mem && rf_we))) begin
        errors++;
        $display("FAIL R7 op=%h actual=%b expected=exclusive actions", op, observed());
      end
    end
  endtask

  task automatic t_back_to_back;
    drive_check(6'h2B, 10'b0010010000, "R3 after sweep");
    drive_check(6'h22, 10'b0, "R6 neighbour of load");
    drive_check(6'h23, 10'b1011100000, "R2 after neighbour");
    drive_check(6'h06, 10'b0, "R6 neighbour of branch");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    opcode = 6'h3F;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_rrr_r1();
    t_load_r2();
    t_store_r3();
    t_beq_r4();
    t_jump_r5();
    t_sweep_r6_r7();
    t_back_to_back();
    finish_run();
  end
endmodule